// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block has two timer/counters. Each one has a low count byte and a high count byte. A shared mode byte sets how the two timers behave, and a shared control byte holds one run bit and one overflow flag per timer.

Each timer has an event source, chosen per timer:
- a machine-cycle tick input, or
- a falling edge on that timer's own count pin.

Counting can also be gated by the matching external interrupt pin. The overflow flags go straight out to an interrupt controller, and software clears them through the register port.

Four counting arrangements are available:
- a 13-bit count made of a 5-bit prescaler feeding the high byte;
- a full 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split arrangement. Timer 0 becomes two independent 8-bit counters, and its high byte borrows timer 1's run bit and overflow flag. Timer 1 then runs free and cannot flag its overflow.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0 and both overflow outputs are 0.
- R2: The register port has six addresses, and reads are combinational (`rd_data` follows `addr` in the same cycle). A write takes effect at the clock edge where `wr_en` is high.
  - Address 0 is the mode byte. Bits 7:4 set timer 1 as {gate, counter-select, mode[1:0]}, and bits 3:0 set timer 0 the same way.
  - Address 1 is the control byte: bit 0 run0, bit 1 flag0, bit 2 run1, bit 3 flag1. Its other bits read 0.
  - Addresses 2 and 3 are timer 0's low and high bytes. Addresses 4 and 5 are timer 1's low and high bytes.
  - Addresses 6 and 7 read 0.
- R3: Mode 00 (13-bit) works as follows:
  - Each count step increments low bits 4:0 and keeps low bits 7:5 unchanged.
  - When bits 4:0 are all ones, the step also carries into the high byte.
  - When the high byte and bits 4:0 are all ones, the step clears both and signals overflow.
- R4: Mode 01 (16-bit) treats {high, low} as one count. A step from 0xFFFF gives 0x0000 and signals overflow.
- R5: Mode 10 (reload) counts in the low byte only. A step from 0xFF loads the high byte into the low byte and signals overflow. The high byte does not change.
- R6: Mode 11 on timer 0 splits it into two 8-bit counters:
  - The low byte steps under run0, timer 0's gate and timer 0's event source, and it sets flag0 when it wraps from 0xFF.
  - The high byte steps on every tick while run1 is 1, and it sets flag1 when it wraps from 0xFF.
- R7: While timer 0 is split, timer 1 keeps counting in its own mode, subject only to its gate condition and with run1 ignored. Its overflows never set flag1. Timer 1 set to mode 11 holds both of its bytes.
- R8: A timer steps only when its run bit is 1 and either its gate bit is 0 or its gate pin is high.
- R9: When counter-select is 0, an event is `tick` high at a clock edge. When counter-select is 1, `tick` is ignored and an event is a count pin that was high at the previous edge and is low at this edge.
- R10: An overflow sets its flag, and the flag stays set until software writes the control byte. `ovf_flag[0]` is flag0 and `ovf_flag[1]` is flag1.
- R11: A write to a count byte wins over a hardware update of that byte in the same cycle. A write to the control byte wins over a hardware flag set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Machine-cycle tick |
| cnt_pin | input | 2 | External count pins, bit i for timer i |
| gate_pin | input | 2 | External gate (interrupt) pins, bit i for timer i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| ovf_flag | output | 2 | Overflow flags to the interrupt controller |

## Verification
Directed cases load each mode's count just below rollover, so that a wrong carry point or a missing reload shows up as a wrong byte value. They also compare:
- the gate pin held low against held high;
- tick pulses against count-pin edges with counter-select set;
- write-versus-overflow collisions, which separate the priority order.

A randomized run then mixes register writes (including mode changes while counting) with random tick, count-pin and gate-pin activity. It compares every readable byte and both flags against a model in the bench, which exposes errors in how the two timers interact in split mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int BYTE_W  = 8;
  parameter int PRE_W   = 5;
  parameter int NUM_TMR = 2;
  parameter int ADDR_W  = 3;
  localparam int WIDE_W = 2 * BYTE_W + 1;
  localparam int NIB_W  = 4;

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(2);

  typedef enum logic [1:0] {
    TM_PRESCALE = 2'b00,
    TM_WIDE     = 2'b01,
    TM_RELOAD   = 2'b10,
    TM_SPLIT    = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic              ovf;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } tmr_next_t;

  // One count step of a timer in the given mode; split mode covers the low byte only.
  function automatic tmr_next_t tmr_advance(tmr_mode_e md, logic [BYTE_W-1:0] lo,
                                            logic [BYTE_W-1:0] hi);
    tmr_next_t n;
    logic [WIDE_W-1:0] wide;
    n.ovf = 1'b0;
    n.hi  = hi;
    n.lo  = lo;
    wide  = '0;
    case (md)
      TM_PRESCALE: begin
        n.lo[PRE_W-1:0] = lo[PRE_W-1:0] + PRE_W'(1);
        if (&lo[PRE_W-1:0]) begin
          n.hi  = hi + BYTE_W'(1);
          n.ovf = &hi;
        end
      end
      TM_WIDE: begin
        wide = {1'b0, hi, lo} + WIDE_W'(1);
        n    = tmr_next_t'(wide);
      end
      TM_RELOAD: begin
        if (&lo) begin
          n.lo  = hi;
          n.ovf = 1'b1;
        end else begin
          n.lo = lo + BYTE_W'(1);
        end
      end
      default: begin
        n.lo  = lo + BYTE_W'(1);
        n.ovf = &lo;
      end
    endcase
    return n;
  endfunction
endpackage

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  logic [N-1:0] pin_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q[i] <= 1'b0;
      else        pin_q[i] <= pin[i];
    end
    assign fall[i] = pin_q[i] & ~pin[i];
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              step,
  input  logic              hi_step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf,
  output logic              hi_ovf
);
  tmr_next_t         adv;
  logic              lo_en;
  logic              split_hi_en;
  logic [BYTE_W-1:0] lo_d;
  logic [BYTE_W-1:0] hi_d;

  assign adv         = tmr_advance(mode, lo_q, hi_q);
  assign lo_en       = step && (SPLIT_OK || (mode != TM_SPLIT));
  assign split_hi_en = SPLIT_OK && (mode == TM_SPLIT) && hi_step;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    ovf    = 1'b0;
    hi_ovf = 1'b0;
    if (lo_en) begin
      lo_d = adv.lo;
      hi_d = adv.hi;
      ovf  = adv.ovf;
    end
    if (split_hi_en) begin
      hi_d   = hi_q + BYTE_W'(1);
      hi_ovf = &hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo ? wr_data : lo_d;
      hi_q <= wr_hi ? wr_data : hi_d;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [NUM_TMR-1:0] cnt_pin,
  input  logic [NUM_TMR-1:0] gate_pin,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [BYTE_W-1:0]  rd_data,
  output logic [NUM_TMR-1:0] ovf_flag
);
  logic [NUM_TMR*NIB_W-1:0] mode_q;
  logic [NUM_TMR-1:0]       run_q;
  logic [NUM_TMR-1:0]       flag_q;

  logic [NUM_TMR-1:0] gate_b, ct_b, gate_ok, ev, run_eff, step, fall;
  logic [NUM_TMR-1:0] ovf_b, hovf_b, set_evt;
  tmr_mode_e          md_b [NUM_TMR];
  logic [BYTE_W-1:0]  lo_b [NUM_TMR];
  logic [BYTE_W-1:0]  hi_b [NUM_TMR];
  logic               split;
  logic               hi_step0;
  logic               wr_mode, wr_ctrl;

  assign wr_mode = wr_en && (addr == A_MODE);
  assign wr_ctrl = wr_en && (addr == A_CTRL);

  tmr_pin_edge #(.N(NUM_TMR)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (cnt_pin),
    .fall (fall)
  );

  assign split    = (md_b[0] == TM_SPLIT);
  assign hi_step0 = run_q[1] & tick;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic wr_lo_i, wr_hi_i;
    assign gate_b[i]  = mode_q[i*NIB_W+3];
    assign ct_b[i]    = mode_q[i*NIB_W+2];
    assign md_b[i]    = tmr_mode_e'(mode_q[i*NIB_W+1 -: 2]);
    assign gate_ok[i] = ~gate_b[i] | gate_pin[i];
    assign ev[i]      = ct_b[i] ? fall[i] : tick;
    assign run_eff[i] = (i == 0) ? run_q[i] : (run_q[i] | split);
    assign step[i]    = run_eff[i] & gate_ok[i] & ev[i];
    assign wr_lo_i    = wr_en && (addr == A_BYTE + ADDR_W'(2*i));
    assign wr_hi_i    = wr_en && (addr == A_BYTE + ADDR_W'(2*i+1));

    tmr_core #(.SPLIT_OK(i == 0)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (md_b[i]),
      .step   (step[i]),
      .hi_step((i == 0) ? hi_step0 : 1'b0),
      .wr_lo  (wr_lo_i),
      .wr_hi  (wr_hi_i),
      .wr_data(wr_data),
      .lo_q   (lo_b[i]),
      .hi_q   (hi_b[i]),
      .ovf    (ovf_b[i]),
      .hi_ovf (hovf_b[i])
    );
  end

  // Flag sources: timer 1's flag is lent to timer 0's high byte in split mode.
  assign set_evt[0] = ovf_b[0];
  assign set_evt[1] = split ? hovf_b[0] : (ovf_b[1] | hovf_b[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wr_data;
      if (wr_ctrl) begin
        run_q  <= {wr_data[2], wr_data[0]};
        flag_q <= {wr_data[3], wr_data[1]};
      end else begin
        flag_q <= flag_q | set_evt;
      end
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(0): rd_data = mode_q;
      ADDR_W'(1): rd_data = {4'b0, flag_q[1], run_q[1], flag_q[0], run_q[0]};
      ADDR_W'(2): rd_data = lo_b[0];
      ADDR_W'(3): rd_data = hi_b[0];
      ADDR_W'(4): rd_data = lo_b[1];
      ADDR_W'(5): rd_data = hi_b[1];
      default:    rd_data = '0;
    endcase
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [BYTE_W-1:0]  wr_data,
  input logic [7:0]         mode_q,
  input logic [NUM_TMR-1:0] run_q,
  input logic [NUM_TMR-1:0] flag_q,
  input logic [NUM_TMR-1:0] step,
  input logic [NUM_TMR-1:0] set_evt,
  input logic [BYTE_W-1:0]  t0_lo,
  input logic [BYTE_W-1:0]  t0_hi,
  input logic [BYTE_W-1:0]  t1_lo,
  input logic [BYTE_W-1:0]  t1_hi
);
  logic ctrl_wr, t0l_wr, t1_wr;
  assign ctrl_wr = wr_en && (addr == ADDR_W'(1));
  assign t0l_wr  = wr_en && (addr == ADDR_W'(2));
  assign t1_wr   = wr_en && ((addr == ADDR_W'(4)) || (addr == ADDR_W'(5)));

  // R10
  flag0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[0] && !ctrl_wr |=> flag_q[0]);

  // R10
  flag0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q[0] && !set_evt[0] && !ctrl_wr |=> !flag_q[0]);

  // R11
  lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t0l_wr |=> t0_lo == $past(wr_data));

  // R8
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q[0] && !t0l_wr |=> $stable(t0_lo));

  // R7
  t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[5:4] == 2'b11 && !t1_wr |=> $stable(t1_lo) && $stable(t1_hi));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1:0] == 2'b10 && step[0] && (&t0_lo) && !t0l_wr |=> t0_lo == $past(t0_hi));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .addr   (addr),
  .wr_data(wr_data),
  .mode_q (mode_q),
  .run_q  (run_q),
  .flag_q (flag_q),
  .step   (step),
  .set_evt(set_evt),
  .t0_lo  (lo_b[0]),
  .t0_hi  (hi_b[0]),
  .t1_lo  (lo_b[1]),
  .t1_hi  (hi_b[1])
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] cnt_pin = 2'b00;
  logic [1:0] gate_pin = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] ovf_flag;

  logic [1:0] cp = 2'b00;
  logic [1:0] gp = 2'b00;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [7:0] m_mode = 8'h00;
  logic [1:0] m_run = 2'b00;
  logic [1:0] m_flag = 2'b00;
  logic [1:0] m_pin = 2'b00;
  logic [7:0] m_b [4] = '{8'h00, 8'h00, 8'h00, 8'h00};

  always #2 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  // Model step: {overflow, high, low}
  function automatic logic [16:0] adv(input logic [1:0] md, input logic t1,
                                      input logic [7:0] lo, input logic [7:0] hi);
    logic [16:0] v;
    case (md)
      2'd0: begin
        v = {4'b0, hi, lo[4:0]} + 17'd1;
        return {v[13], v[12:5], lo[7:5], v[4:0]};
      end
      2'd1: return {1'b0, hi, lo} + 17'd1;
      2'd2: return (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
      default: return t1 ? {1'b0, hi, lo} : {lo == 8'hFF, hi, lo + 8'd1};
    endcase
  endfunction

  function automatic logic [7:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return {4'b0, m_flag[1], m_run[1], m_flag[0], m_run[0]};
      3'd2, 3'd3, 3'd4, 3'd5: return m_b[a - 3'd2];
      default: return 8'h00;
    endcase
  endfunction

  task automatic cyc(input logic t, input logic we, input logic [2:0] a, input logic [7:0] d);
    logic [16:0] r0, r1;
    logic split, e0, e1, s0, s1, sh, f0, f1;
    logic [7:0] nb [4];
    @(negedge clk);
    tick = t; wr_en = we; addr = a; wr_data = d; cnt_pin = cp; gate_pin = gp;
    split = (m_mode[1:0] == 2'b11);
    e0 = m_mode[2] ? (m_pin[0] & ~cp[0]) : t;
    e1 = m_mode[6] ? (m_pin[1] & ~cp[1]) : t;
    s0 = m_run[0] & (~m_mode[3] | gp[0]) & e0;
    s1 = (split | m_run[1]) & (~m_mode[7] | gp[1]) & e1;
    sh = split & m_run[1] & t;
    r0 = s0 ? adv(m_mode[1:0], 1'b0, m_b[0], m_b[1]) : {1'b0, m_b[1], m_b[0]};
    r1 = s1 ? adv(m_mode[5:4], 1'b1, m_b[2], m_b[3]) : {1'b0, m_b[3], m_b[2]};
    nb[0] = r0[7:0]; nb[1] = r0[15:8]; nb[2] = r1[7:0]; nb[3] = r1[15:8];
    if (sh) nb[1] = m_b[1] + 8'd1;
    f0 = r0[16];
    f1 = split ? (sh && m_b[1] == 8'hFF) : r1[16];
    @(posedge clk);
    if (we && a >= 3'd2 && a <= 3'd5) nb[a - 3'd2] = d;
    if (we && a == 3'd1) begin
      m_run = {d[2], d[0]};
      m_flag = {d[3], d[1]};
    end else begin
      m_flag = m_flag | {f1, f0};
    end
    if (we && a == 3'd0) m_mode = d;
    for (int k = 0; k < 4; k++) m_b[k] = nb[k];
    m_pin = cp;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; addr = a; #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_err++;
      $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_ovf(input logic [1:0] exp, input string tag);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; #1;
    n_chk++;
    if (ovf_flag !== exp) begin
      n_err++;
      $display("FAIL %s ovf_flag actual %b expected %b", tag, ovf_flag, exp);
    end
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [2:0] ra;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 6; a++) chk(3'(a), 8'h00, "R1");
    chk_ovf(2'b00, "R1");

    // R3 13-bit prescale rollover, R2 mode readback
    wr(0, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h01);
    chk(1, 8'h01, "R2");
    ticks(1); chk(2, 8'hFF, "R3"); chk_ovf(2'b00, "R3");
    ticks(1); chk(2, 8'hE0, "R3"); chk(3, 8'h00, "R3"); chk_ovf(2'b01, "R10");
    wr(2, 8'h1F); wr(3, 8'h05); ticks(1);
    chk(2, 8'h00, "R3"); chk(3, 8'h06, "R3");

    // R10 flag cleared by software only
    ticks(2); chk_ovf(2'b01, "R10");
    wr(1, 8'h01); chk_ovf(2'b00, "R10");

    // R4 16-bit rollover
    wr(0, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF);
    ticks(1); chk(2, 8'hFF, "R4"); chk(3, 8'hFF, "R4"); chk_ovf(2'b00, "R4");
    ticks(1); chk(2, 8'h00, "R4"); chk(3, 8'h00, "R4"); chk_ovf(2'b01, "R4");

    // R5 auto-reload
    wr(1, 8'h01); wr(0, 8'h02); wr(3, 8'hA0); wr(2, 8'hFE);
    ticks(1); chk(2, 8'hFF, "R5");
    ticks(1); chk(2, 8'hA0, "R5"); chk(3, 8'hA0, "R5"); chk_ovf(2'b01, "R5");

    // R8 run bit and gate pin
    wr(1, 8'h00); ticks(3); chk(2, 8'hA0, "R8");
    wr(0, 8'h09); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h01);
    gp = 2'b00; ticks(2); chk(2, 8'h00, "R8");
    gp = 2'b01; ticks(2); chk(2, 8'h02, "R8");
    gp = 2'b00;

    // R9 count-pin edges versus tick
    wr(0, 8'h05); wr(2, 8'h00);
    ticks(3); chk(2, 8'h00, "R9");
    cp = 2'b01; cyc(1'b1, 1'b0, 3'd0, 8'h00); chk(2, 8'h00, "R9");
    cp = 2'b00; cyc(1'b0, 1'b0, 3'd0, 8'h00); chk(2, 8'h01, "R9");

    // R6 split mode: high byte on run1 and flag1
    wr(1, 8'h00); wr(0, 8'h03); wr(3, 8'hFF); wr(2, 8'h10); wr(1, 8'h04);
    ticks(1);
    chk(3, 8'h00, "R6"); chk(2, 8'h10, "R6"); chk_ovf(2'b10, "R6");

    // R7 timer 1 free-running while split, no flag; mode 11 holds
    wr(1, 8'h04); wr(0, 8'h13); wr(4, 8'hFF); wr(5, 8'hFF); wr(1, 8'h00);
    ticks(1);
    chk(4, 8'h00, "R7"); chk(5, 8'h00, "R7"); chk_ovf(2'b00, "R7");
    wr(0, 8'h31); wr(1, 8'h04); wr(4, 8'h55);
    ticks(3); chk(4, 8'h55, "R7");

    // R11 write wins over hardware update
    wr(1, 8'h01); wr(0, 8'h01); wr(2, 8'h10);
    cyc(1'b1, 1'b1, 3'd2, 8'h77); chk(2, 8'h77, "R11");
    wr(2, 8'hFF); wr(3, 8'hFF);
    cyc(1'b1, 1'b1, 3'd1, 8'h01);
    chk_ovf(2'b00, "R11"); chk(2, 8'h00, "R11"); chk(3, 8'h00, "R11");

    // Randomized mix against the bench model
    for (int it = 0; it < 2500; it++) begin
      logic we;
      cp = 2'($urandom); gp = 2'($urandom);
      we = ($urandom % 6) == 0;
      cyc(1'($urandom), we, 3'($urandom), 8'($urandom));
      ra = 3'($urandom);
      chk(ra, m_rd(ra), (ra == 3'd1) ? "R10" : (ra >= 3'd2 && ra <= 3'd5) ? "R4" : "R2");
      chk_ovf(m_flag, "R10");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule